// File: doc/BRIEF.md
# Processor trace status encoder

This block turns per-cycle event strobes from a processor core into a 4-bit status code on a narrow trace port. Each cycle the port carries one nibble. It shows either a status code for the highest-priority event of the previous cycle, or `0x0` when execution simply continues. Taken branches that jump through a computed target can also stream that target address onto the same port. The stream starts with a byte-count marker, and the address bytes follow, least significant first.

A multi-nibble sequence owns the port until its last nibble has gone out. Examples are a captured address, or a breakpoint code followed by its trigger status. Events that arrive during such a sequence wait in a small FIFO and are replayed in arrival order. Modes that last several cycles, such as exception processing, stop or halt, are signalled by holding their strobe high. The code then repeats on every cycle the strobe is high.

Top module: `trc_status_enc`

## Requirements
- R1: During reset, and while no event is pending and no sequence is in progress, the port shows `0x0`. Reset abandons any sequence in progress and empties the queue.
- R2: A taken branch shows `0x5` on the cycle after its strobe. It shows only `0x5` when the branch is not marked variant or when capture is disabled (`cap_en` = 0).
- R3: A folded branch shows `0x6`, and a return from exception shows `0x7`, each for one cycle.
- R4: A variant taken branch, or a PC sync request, with `cap_en` = 1 shows `0x5`, then the marker `0x8 + cap_bytes`, then the data. The marker sits exactly one cycle before the first data nibble.
- R5: The data has `cap_bytes + 1` bytes of `tgt_addr`, least significant byte first. Each byte is sent as two nibbles, low nibble first.
- R6: Each cycle `evt_exc` is high, the port shows `0xC` on the next cycle. Each cycle `evt_emu_exc` is high, it shows `0xD`.
- R7: A breakpoint state change shows `0xE` for exactly one cycle. The 4-bit `bkpt_status` captured with it follows on the next cycle.
- R8: Each cycle `evt_stop` is high, the port shows `0xE`, with no status nibble after it.
- R9: Each cycle `evt_halt` is high, the port shows `0xF`.
- R10: When several strobes are high in one cycle, one event is taken. The priority from highest to lowest is halt, emulator exception, exception, stop, breakpoint change, return from exception, folded branch, taken branch or PC sync.
- R11: Events that arrive while a sequence is running, or while events are queued, are stored in a FIFO of `FIFO_DEPTH` entries and replayed in arrival order after the current sequence. An event that arrives when the FIFO is full and nothing leaves it that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_taken | input | 1 | Taken branch begins execution |
| evt_variant | input | 1 | Qualifies `evt_taken`: the branch target was computed (register-indirect, indexed, return, vector) |
| evt_pc_sync | input | 1 | PC sync request; reported as `0x5` with address capture |
| evt_folded | input | 1 | Folded conditional branch with its target starting |
| evt_rte | input | 1 | Return from exception begins |
| evt_exc | input | 1 | Normal exception processing in progress |
| evt_emu_exc | input | 1 | Emulator-mode exception processing in progress |
| evt_halt | input | 1 | Processor halted |
| evt_stop | input | 1 | Processor stopped waiting for an interrupt |
| evt_bkpt | input | 1 | Breakpoint state change |
| bkpt_status | input | 4 | Trigger status value for a breakpoint change |
| tgt_addr | input | 32 | Branch target address to capture |
| cap_en | input | 1 | Enables address capture |
| cap_bytes | input | 2 | Number of address bytes minus one (0 to 3 mean 1 to 4 bytes) |
| trace_nib | output | 4 | Registered trace port nibble |

## Verification
The port is registered, so every result first appears on the cycle after the edge that samples the strobe, provided the port is free. A queued event instead appears on the cycle after the last nibble of the sequence ahead of it. Within a sequence, the marker follows the `0x5` by one cycle and each data nibble follows one cycle later. A breakpoint status follows its `0xE` by one cycle. The bench steps a behavioural model at each rising edge on the same inputs, keeping the remaining nibbles and the waiting events in queues. It compares the port with the model's value at every falling edge, half a cycle after the port has updated, so every latency above is checked on the exact cycle it falls due.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int NIB_W  = 4;
  localparam int ADDR_W = 32;
  localparam int BCNT_W = 2;
  localparam int LEFT_W = $clog2(2 * (ADDR_W / 8) + 1);

  localparam logic [NIB_W-1:0] CODE_IDLE   = 4'h0;
  localparam logic [NIB_W-1:0] CODE_BRANCH = 4'h5;
  localparam logic [NIB_W-1:0] CODE_FOLD   = 4'h6;
  localparam logic [NIB_W-1:0] CODE_RTE    = 4'h7;
  localparam logic [NIB_W-1:0] CODE_EXC    = 4'hC;
  localparam logic [NIB_W-1:0] CODE_EMU    = 4'hD;
  localparam logic [NIB_W-1:0] CODE_STOP   = 4'hE;
  localparam logic [NIB_W-1:0] CODE_HALT   = 4'hF;

  // One queued event: head code, optional byte-count marker, trailing data
  typedef struct packed {
    logic [NIB_W-1:0]  head;
    logic              mark;
    logic [BCNT_W-1:0] bcnt;
    logic [LEFT_W-1:0] ndat;
    logic [ADDR_W-1:0] data;
  } trc_rec_t;

  localparam int REC_W = $bits(trc_rec_t);

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_HEAD = 2'd1,
    K_MARK = 2'd2,
    K_DATA = 2'd3
  } trc_kind_e;

endpackage

// File: rtl/trc_evt_sel.sv
module trc_evt_sel
  import trc_pkg::*;
(
  input  logic              evt_taken,
  input  logic              evt_variant,
  input  logic              evt_pc_sync,
  input  logic              evt_folded,
  input  logic              evt_rte,
  input  logic              evt_exc,
  input  logic              evt_emu_exc,
  input  logic              evt_halt,
  input  logic              evt_stop,
  input  logic              evt_bkpt,
  input  logic [NIB_W-1:0]  bkpt_status,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              cap_en,
  input  logic [BCNT_W-1:0] cap_bytes,
  output logic              sel_valid,
  output trc_rec_t          sel_rec
);

  logic capture;

  assign capture = cap_en & ((evt_taken & evt_variant) | evt_pc_sync);

  // Fixed priority: halt, emulator exception, exception, stop, breakpoint,
  // return from exception, folded branch, taken branch / PC sync
  always_comb begin
    sel_rec   = '0;
    sel_valid = 1'b1;
    if (evt_halt) begin
      sel_rec.head = CODE_HALT;
    end else if (evt_emu_exc) begin
      sel_rec.head = CODE_EMU;
    end else if (evt_exc) begin
      sel_rec.head = CODE_EXC;
    end else if (evt_stop) begin
      sel_rec.head = CODE_STOP;
    end else if (evt_bkpt) begin
      sel_rec.head = CODE_STOP;
      sel_rec.ndat = LEFT_W'(1);
      sel_rec.data = {{(ADDR_W-NIB_W){1'b0}}, bkpt_status};
    end else if (evt_rte) begin
      sel_rec.head = CODE_RTE;
    end else if (evt_folded) begin
      sel_rec.head = CODE_FOLD;
    end else if (evt_taken || evt_pc_sync) begin
      sel_rec.head = CODE_BRANCH;
      if (capture) begin
        sel_rec.mark = 1'b1;
        sel_rec.bcnt = cap_bytes;
        sel_rec.ndat = (LEFT_W'(cap_bytes) + LEFT_W'(1)) << 1;
        sel_rec.data = tgt_addr;
      end
    end else begin
      sel_valid = 1'b0;
    end
  end

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [WIDTH-1:0]              wdata,
  input  logic                          pop,
  output logic [WIDTH-1:0]              rdata,
  output logic                          empty,
  output logic [$clog2(DEPTH+1)-1:0]    count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign rdata   = slot_q[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + PTR_W'(1);
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + PTR_W'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push & (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[i] <= wdata;
    end
  end

endmodule

// File: rtl/trc_emit.sv
module trc_emit
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  trc_rec_t         in_rec,
  input  logic             q_empty,
  input  trc_rec_t         q_rec,
  output logic             q_push,
  output logic             q_pop,
  output logic             busy,
  output logic [NIB_W-1:0] trace,
  output trc_kind_e        kind
);

  logic [NIB_W-1:0]  trace_q, trace_d;
  trc_kind_e         kind_q, kind_d;
  logic              mark_q, mark_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [ADDR_W-1:0] data_q, data_d;
  logic              data_en, load;
  trc_rec_t          src;

  assign busy  = mark_q | (left_q != '0);
  assign trace = trace_q;
  assign kind  = kind_q;

  always_comb begin
    trace_d = CODE_IDLE;
    kind_d  = K_IDLE;
    mark_d  = mark_q;
    bcnt_d  = bcnt_q;
    left_d  = left_q;
    data_d  = data_q;
    data_en = 1'b0;
    q_push  = 1'b0;
    q_pop   = 1'b0;
    load    = 1'b0;
    src     = in_rec;
    if (busy) begin
      q_push = in_valid;
      if (mark_q) begin
        trace_d = {2'b10, bcnt_q};
        kind_d  = K_MARK;
        mark_d  = 1'b0;
      end else begin
        trace_d = data_q[NIB_W-1:0];
        kind_d  = K_DATA;
        data_d  = data_q >> NIB_W;
        data_en = 1'b1;
        left_d  = left_q - LEFT_W'(1);
      end
    end else if (!q_empty) begin
      q_pop  = 1'b1;
      q_push = in_valid;
      load   = 1'b1;
      src    = q_rec;
    end else if (in_valid) begin
      load = 1'b1;
    end
    if (load) begin
      trace_d = src.head;
      kind_d  = K_HEAD;
      mark_d  = src.mark;
      bcnt_d  = src.bcnt;
      left_d  = src.ndat;
      data_d  = src.data;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_q <= CODE_IDLE;
      kind_q  <= K_IDLE;
      mark_q  <= 1'b0;
      bcnt_q  <= '0;
      left_q  <= '0;
    end else begin
      trace_q <= trace_d;
      kind_q  <= kind_d;
      mark_q  <= mark_d;
      bcnt_q  <= bcnt_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/trc_status_enc.sv
module trc_status_enc
  import trc_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_taken,
  input  logic        evt_variant,
  input  logic        evt_pc_sync,
  input  logic        evt_folded,
  input  logic        evt_rte,
  input  logic        evt_exc,
  input  logic        evt_emu_exc,
  input  logic        evt_halt,
  input  logic        evt_stop,
  input  logic        evt_bkpt,
  input  logic [3:0]  bkpt_status,
  input  logic [31:0] tgt_addr,
  input  logic        cap_en,
  input  logic [1:0]  cap_bytes,
  output logic [3:0]  trace_nib
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             [1:0] rst_sync_q;
  logic                   rst_s_n;
  logic                   sel_valid;
  trc_rec_t               sel_rec;
  logic                   q_push, q_pop, q_empty, emit_busy;
  logic [REC_W-1:0]       q_rdata;
  logic [CNT_W-1:0]       q_count;
  trc_kind_e              out_kind;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  trc_evt_sel u_sel (
    .evt_taken   (evt_taken),
    .evt_variant (evt_variant),
    .evt_pc_sync (evt_pc_sync),
    .evt_folded  (evt_folded),
    .evt_rte     (evt_rte),
    .evt_exc     (evt_exc),
    .evt_emu_exc (evt_emu_exc),
    .evt_halt    (evt_halt),
    .evt_stop    (evt_stop),
    .evt_bkpt    (evt_bkpt),
    .bkpt_status (bkpt_status),
    .tgt_addr    (tgt_addr),
    .cap_en      (cap_en),
    .cap_bytes   (cap_bytes),
    .sel_valid   (sel_valid),
    .sel_rec     (sel_rec)
  );

  trc_fifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (REC_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_s_n),
    .push  (q_push),
    .wdata (sel_rec),
    .pop   (q_pop),
    .rdata (q_rdata),
    .empty (q_empty),
    .count (q_count)
  );

  trc_emit u_emit (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (sel_valid),
    .in_rec   (sel_rec),
    .q_empty  (q_empty),
    .q_rec    (trc_rec_t'(q_rdata)),
    .q_push   (q_push),
    .q_pop    (q_pop),
    .busy     (emit_busy),
    .trace    (trace_nib),
    .kind     (out_kind)
  );

endmodule

// File: rtl/trc_status_enc_chk.sv
module trc_status_enc_chk
  import trc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_s_n,
  input logic [3:0]                 trace,
  input trc_kind_e                  kind,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic                       sel_valid,
  input logic                       q_empty,
  input logic                       busy,
  input logic                       halt
);

  // R1: nothing selected, nothing queued, nothing running -> continue code
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sel_valid && q_empty && !busy) |=> (trace == 4'h0));

  // R9: a halt with a free port shows the halt code next cycle
  a_r9_halt_code: assert property (@(posedge clk) disable iff (!rst_s_n)
    (halt && q_empty && !busy) |=> (trace == 4'hF));

  // R4: the marker is always followed directly by a data nibble
  a_r4_mark_then_data: assert property (@(posedge clk) disable iff (!rst_s_n)
    (kind == K_MARK) |=> (kind == K_DATA));

  // R4: the marker directly follows the taken-branch code
  a_r4_mark_after_branch: assert property (@(posedge clk) disable iff (!rst_s_n)
    (kind == K_MARK) |-> ($past(kind) == K_HEAD && $past(trace) == 4'h5));

  // R11: the queue never holds more than its depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));

endmodule

bind trc_status_enc trc_status_enc_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .trace     (trace_nib),
  .kind      (out_kind),
  .cnt       (q_count),
  .sel_valid (sel_valid),
  .q_empty   (q_empty),
  .busy      (emit_busy),
  .halt      (evt_halt)
);

// File: tb/tb_trc_status_enc.sv
`timescale 1ns/1ps
module tb_trc_status_enc;

  localparam int DEPTH = 4;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_taken, evt_variant, evt_pc_sync, evt_folded, evt_rte;
  logic        evt_exc, evt_emu_exc, evt_halt, evt_stop, evt_bkpt;
  logic [3:0]  bkpt_status;
  logic [31:0] tgt_addr;
  logic        cap_en;
  logic [1:0]  cap_bytes;
  logic [3:0]  trace_nib;

  always #10 clk = ~clk;

  trc_status_enc #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .evt_taken(evt_taken), .evt_variant(evt_variant), .evt_pc_sync(evt_pc_sync),
    .evt_folded(evt_folded), .evt_rte(evt_rte), .evt_exc(evt_exc),
    .evt_emu_exc(evt_emu_exc), .evt_halt(evt_halt), .evt_stop(evt_stop),
    .evt_bkpt(evt_bkpt), .bkpt_status(bkpt_status), .tgt_addr(tgt_addr),
    .cap_en(cap_en), .cap_bytes(cap_bytes), .trace_nib(trace_nib)
  );

  typedef struct {
    int          h;
    int          kd;   // 0 plain, 1 breakpoint status, 2 address capture
    int          nb;
    logic [31:0] aux;
  } ev_t;

  ev_t   evq[$];
  int    nibq[$];
  int    exp_nib = 0;
  int    n_vec = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic bit decode(output ev_t e);
    e.h = 0; e.kd = 0; e.nb = 0; e.aux = '0;
    if (evt_halt)          e.h = 15;
    else if (evt_emu_exc)  e.h = 13;
    else if (evt_exc)      e.h = 12;
    else if (evt_stop)     e.h = 14;
    else if (evt_bkpt)   begin e.h = 14; e.kd = 1; e.aux = 32'(bkpt_status); end
    else if (evt_rte)      e.h = 7;
    else if (evt_folded)   e.h = 6;
    else if (evt_taken || evt_pc_sync) begin
      e.h = 5;
      if (cap_en && ((evt_taken && evt_variant) || evt_pc_sync)) begin
        e.kd = 2; e.nb = int'(cap_bytes) + 1; e.aux = tgt_addr;
      end
    end else return 1'b0;
    return 1'b1;
  endfunction

  task automatic expand(input ev_t e);
    nibq.push_back(e.h);
    if (e.kd == 1) nibq.push_back(int'(e.aux[3:0]));
    if (e.kd == 2) begin
      nibq.push_back(8 + e.nb - 1);
      for (int b = 0; b < 2 * e.nb; b++) nibq.push_back(int'((e.aux >> (4 * b)) & 32'hF));
    end
  endtask

  // Reference model, stepped on the same edge that samples the inputs
  always @(posedge clk) begin
    ev_t e, cur;
    bit  have;
    cyc++;
    if (!rst_n) begin
      nibq.delete(); evq.delete(); exp_nib = 0;
    end else begin
      have = decode(e);
      if (nibq.size() > 0) begin
        exp_nib = nibq.pop_front();
        if (have && evq.size() < DEPTH) evq.push_back(e);
      end else if (evq.size() > 0) begin
        cur = evq.pop_front();
        expand(cur);
        exp_nib = nibq.pop_front();
        if (have) evq.push_back(e);
      end else if (have) begin
        expand(e);
        exp_nib = nibq.pop_front();
      end else begin
        exp_nib = 0;
      end
    end
    chk_on = 1;
  end

  // Compare half a cycle after the port updates
  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_vec++;
      if (trace_nib !== 4'(exp_nib)) begin
        n_fail++;
        $display("FAIL %s cycle %0d: trace_nib=%h expected=%h", cur_req, cyc, trace_nib, 4'(exp_nib));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected under %0d)", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic clear_in();
    evt_taken = 0; evt_variant = 0; evt_pc_sync = 0; evt_folded = 0; evt_rte = 0;
    evt_exc = 0; evt_emu_exc = 0; evt_halt = 0; evt_stop = 0; evt_bkpt = 0;
  endtask

  task automatic idle(input int n);
    clear_in();
    repeat (n) @(negedge clk);
  endtask

  task automatic one();
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    rst_n = 1'b0;
    clear_in();
    bkpt_status = 4'h0; tgt_addr = 32'h0; cap_en = 1'b0; cap_bytes = 2'd0;
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);

    // R2: plain taken branch, variant with capture off, PC sync with capture off
    cur_req = "R2";
    evt_taken = 1; one(); idle(2);
    evt_taken = 1; evt_variant = 1; tgt_addr = 32'hDEADBEEF; one(); idle(2);
    evt_pc_sync = 1; one(); idle(2);
    cap_en = 1; evt_taken = 1; one(); idle(2);

    // R3: folded branch and return from exception
    cur_req = "R3";
    evt_folded = 1; one(); evt_rte = 1; one(); idle(2);

    // R4 / R5: captures of 1 to 4 bytes
    cur_req = "R4_R5";
    for (int n = 0; n < 4; n++) begin
      cap_bytes = 2'(n);
      tgt_addr = 32'h87654321 + 32'(n * 32'h01010101);
      evt_taken = 1; evt_variant = 1; one(); idle(12);
    end
    cap_bytes = 2'd1; tgt_addr = 32'h0000A5C3;
    evt_pc_sync = 1; one(); idle(8);

    // R6: held exception modes
    cur_req = "R6";
    evt_exc = 1; repeat (3) @(negedge clk); clear_in();
    evt_emu_exc = 1; repeat (3) @(negedge clk); idle(2);

    // R7: breakpoint change followed by status
    cur_req = "R7";
    bkpt_status = 4'hA; evt_bkpt = 1; one(); idle(3);
    bkpt_status = 4'h3; evt_bkpt = 1; one(); evt_bkpt = 1; bkpt_status = 4'h9; one(); idle(5);

    // R8: stop held
    cur_req = "R8";
    evt_stop = 1; repeat (4) @(negedge clk); idle(2);

    // R9: halt held
    cur_req = "R9";
    evt_halt = 1; repeat (5) @(negedge clk); idle(2);

    // R10: simultaneous strobes
    cur_req = "R10";
    evt_halt = 1; evt_emu_exc = 1; evt_exc = 1; evt_stop = 1; evt_bkpt = 1; evt_rte = 1; evt_taken = 1; one();
    evt_emu_exc = 1; evt_exc = 1; evt_rte = 1; one();
    evt_exc = 1; evt_stop = 1; one();
    evt_stop = 1; evt_bkpt = 1; one();
    bkpt_status = 4'h6; evt_bkpt = 1; evt_rte = 1; evt_folded = 1; one(); idle(2);
    evt_rte = 1; evt_folded = 1; evt_taken = 1; one();
    evt_folded = 1; evt_taken = 1; evt_variant = 1; one(); idle(3);

    // R11: events during a capture are queued and replayed in order
    cur_req = "R11";
    cap_bytes = 2'd3; tgt_addr = 32'h13579BDF;
    evt_taken = 1; evt_variant = 1; one();
    evt_rte = 1; one();
    bkpt_status = 4'h5; evt_bkpt = 1; one();
    evt_folded = 1; one(); idle(20);
    // R11: overflow drops the newest events
    cap_bytes = 2'd3; tgt_addr = 32'hFEDCBA98;
    evt_taken = 1; evt_variant = 1; one();
    evt_rte = 1; one(); evt_folded = 1; one(); evt_exc = 1; one(); evt_stop = 1; one();
    evt_halt = 1; one(); evt_emu_exc = 1; one(); idle(3);
    // queued capture followed by events arriving during its replay
    cap_bytes = 2'd0; tgt_addr = 32'h000000E7;
    evt_rte = 1; one(); evt_taken = 1; evt_variant = 1; one(); evt_folded = 1; one(); idle(14);

    // R1: reset during a transfer abandons it
    cur_req = "R1";
    cap_bytes = 2'd3; tgt_addr = 32'h2468ACE0;
    evt_taken = 1; evt_variant = 1; one();
    evt_rte = 1; one(); idle(2);
    rst_n = 1'b0; idle(2);
    rst_n = 1'b1; idle(8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule